// File: doc/BRIEF.md
# Two-Wire Bus Busy Monitor

This block listens to the clock and data lines of a two-wire (I2C) bus and produces one flag. The flag tells a local master whether another device currently owns the bus, so that the master can hold off before it starts a transfer of its own. The block never drives either line and does not decode bytes.

Both lines are first brought into the system clock domain through a synchroniser. A short majority filter then removes single-sample spikes. The cleaned lines feed an edge detector, which recognises start and stop conditions and any low level on the clock line.

The flag is raised when a start condition appears or when the clock line is seen low. It falls on a stop condition. It also falls after the bus has been quiet for a configurable idle time, which recovers from a master that disappeared without sending a stop. The idle time is counted in system clocks and rounded up.

Top module: `i2c_busy_monitor`

## Requirements
- R1: After reset, with both lines held high, `bus_busy_o` is 0.
- R2: A clock-line low level lasting at least two system clocks sets `bus_busy_o` to 1, even when no start condition came before it.
- R3: Once set, `bus_busy_o` stays 1 after the clock line returns high. It clears only when no line edge has been seen for IDLE_TICKS system clocks, where IDLE_TICKS = ceil(IDLE_NS * CLK_HZ / 1e9). With the defaults of 50000 ns at 125 MHz this is 6250 clocks.
- R4: A start condition (data falling while the clock line is high) sets `bus_busy_o` to 1.
- R5: A stop condition (data rising while the clock line is high) clears `bus_busy_o` within the pipeline latency, without waiting for the idle time.
- R6: Every edge on either cleaned line restarts the idle count from zero.
- R7: A pulse on either line that lasts one system clock is removed by the 3-tap majority filter. It creates no busy, start or stop event.
- R8: The idle count is held at zero while the clock line is low, so a stretched clock never times out the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the pin, asynchronous |
| bus_busy_o | output | 1 | 1 while the bus is judged to be owned by some master |

## Verification
The embedded properties check the following on every cycle:
- a cleaned stop condition always clears the flag on the next clock;
- a cleaned start condition or a low clock level always sets it;
- the idle counter stays in range;
- the counter restarts on every edge and is held while the clock line is low;
- a timeout never fires while the clock line is low.

Only the bench scenarios show the end-to-end behaviour. These include the exact rounding of the idle time, the rejection of one-clock spikes at the pins, and the flag persisting through a clock-line low held for twice the idle time.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  typedef struct packed {
    logic scl;
    logic sda;
  } line_pair_t;

  // Idle time in nanoseconds converted to clock ticks, rounded up.
  function automatic longint idle_ticks(input longint clk_hz, input longint idle_ns);
    longint prod;
    prod = clk_hz * idle_ns;
    return (prod + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int TAPS        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int MAJ = TAPS / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [TAPS-1:0]        win_q;
  logic                   clean_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '1;
      win_q   <= '1;
      clean_q <= 1'b1;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], raw_i};
      win_q   <= {win_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
      clean_q <= ($countones(win_q) > MAJ);
    end
  end

  assign clean_o = clean_q;

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  line_pair_t lines_i,
  output logic       start_o,
  output logic       stop_o,
  output logic       edge_o,
  output logic       scl_low_o
);
  line_pair_t prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
    else        prev_q <= lines_i;
  end

  // Conditions count only when the clock line is high on both samples.
  logic scl_steady_hi;
  assign scl_steady_hi = lines_i.scl && prev_q.scl;

  assign start_o   = scl_steady_hi && prev_q.sda && !lines_i.sda;
  assign stop_o    = scl_steady_hi && !prev_q.sda && lines_i.sda;
  assign edge_o    = (lines_i != prev_q);
  assign scl_low_o = !lines_i.scl;

endmodule

// File: rtl/i2c_idle_timer.sv
module i2c_idle_timer #(
  parameter longint TICKS = 6250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last  = (cnt_q == LAST);
  assign expire_o = run_i && !restart_i && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (restart_i || !run_i)    cnt_q <= '0;
    else if (!at_last)               cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0));
  p_paused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/i2c_busy_monitor.sv
module i2c_busy_monitor
  import i2c_mon_pkg::*;
#(
  parameter longint CLK_HZ      = 125_000_000,
  parameter longint IDLE_NS     = 50_000,
  parameter int     SYNC_STAGES = 2,
  parameter int     FILT_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic bus_busy_o
);
  localparam longint IDLE_TICKS = idle_ticks(CLK_HZ, IDLE_NS);

  logic [1:0] raw_w;
  logic [1:0] clean_w;
  line_pair_t lines;

  assign raw_w = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .TAPS       (FILT_TAPS)
    ) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_w[g]),
      .clean_o(clean_w[g])
    );
  end

  assign lines.scl = clean_w[1];
  assign lines.sda = clean_w[0];

  logic start_evt, stop_evt, edge_evt, scl_low;

  i2c_cond_detect u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines_i  (lines),
    .start_o  (start_evt),
    .stop_o   (stop_evt),
    .edge_o   (edge_evt),
    .scl_low_o(scl_low)
  );

  logic busy_q;
  logic tmr_expire;

  i2c_idle_timer #(.TICKS(IDLE_TICKS)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(edge_evt),
    .run_i    (busy_q && !scl_low),
    .expire_o (tmr_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                      busy_q <= 1'b0;
    else if (stop_evt)               busy_q <= 1'b0;
    else if (start_evt || scl_low)   busy_q <= 1'b1;
    else if (tmr_expire)             busy_q <= 1'b0;
  end

  assign bus_busy_o = busy_q;

  p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !bus_busy_o);
  p_start_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> bus_busy_o);
  p_scl_low_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scl_low |=> bus_busy_o);
  p_no_timeout_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_expire |-> lines.scl);

endmodule

// File: tb/i2c_busy_monitor_test.sv
module i2c_busy_monitor_test;

  localparam longint CLK_HZ  = 125_000_000;
  localparam longint IDLE_NS = 404;
  // R3 rounding: 404 ns * 125 MHz = 50.5 -> 51 clocks
  localparam int TC = 51;
  localparam int HOLD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  i2c_busy_monitor #(.CLK_HZ(CLK_HZ), .IDLE_NS(IDLE_NS)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .bus_busy_o(busy)
  );

  // {scl, sda, expected busy}, each held HOLD clocks
  localparam int NV = 7;
  localparam bit [2:0] VEC [NV] = '{
    3'b110,   // R1 idle after reset
    3'b101,   // R4 start
    3'b001,   // R2 clock low
    3'b101,   // clock high, data still low
    3'b110,   // R5 stop
    3'b011,   // R2 clock low without start
    3'b111    // R3 stays busy after clock high
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: busy=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        n_fail++;
        $display("FAIL watchdog: cycles=%0d expected<=100000", wd);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    cyc(3);
    check(busy, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    cyc(HOLD);
    check(busy, 1'b0, "R1 after reset");

    for (int i = 0; i < NV; i++) begin
      scl = VEC[i][2];
      sda = VEC[i][1];
      cyc(HOLD);
      check(busy, VEC[i][0], $sformatf("R1-5 vector %0d", i));
    end

    // R3: timeout measured from the clock line rising in the last vector
    cyc(TC - 2 * HOLD);
    check(busy, 1'b1, "R3 before timeout");
    cyc(25);
    check(busy, 1'b0, "R3 after timeout");

    // R6: an edge part-way through restarts the idle count
    scl = 1'b0; cyc(4); scl = 1'b1;
    cyc(TC - 20);
    sda = 1'b0;
    cyc(TC - 20);
    check(busy, 1'b1, "R6 restart on edge");
    sda = 1'b1;
    cyc(HOLD);
    check(busy, 1'b0, "R5 stop before timeout");

    // R7: one-clock spikes on either line are ignored
    scl = 1'b0; cyc(1); scl = 1'b1;
    cyc(HOLD);
    check(busy, 1'b0, "R7 clock spike");
    sda = 1'b0; cyc(1); sda = 1'b1;
    cyc(HOLD);
    check(busy, 1'b0, "R7 data spike");

    // R8: a clock line held low for twice the idle time keeps busy
    scl = 1'b0;
    cyc(2 * TC);
    check(busy, 1'b1, "R8 held low");
    scl = 1'b1;
    cyc(HOLD);
    check(busy, 1'b1, "R8 after release");
    sda = 1'b0; cyc(HOLD);
    sda = 1'b1; cyc(HOLD);
    check(busy, 1'b0, "R5 stop after stretch");

    // R1: reset while busy returns the flag to 0
    scl = 1'b0; cyc(HOLD); scl = 1'b1;
    check(busy, 1'b1, "R2 before reset");
    rst_n = 1'b0; cyc(2);
    check(busy, 1'b0, "R1 reset while busy");
    rst_n = 1'b1; cyc(HOLD);
    check(busy, 1'b0, "R1 idle after second reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule